// File: doc/BRIEF.md
# Descriptor-Driven XOR/Copy Execution Unit

This unit takes one 32-bit control word and a byte count, and runs a single operation over streamed source words. A copy passes the words of source 0 straight through. An XOR parity operation combines word k of every active source into output word k. A no-op moves no data and only reports completion. Source words reach the unit on one shared valid/ready stream, and each word carries the index of the source it belongs to. Words from different sources may arrive in any order within a word position. Results leave on a valid/ready stream with a byte-keep mask and a last flag.

When an operation finishes, the unit raises a one-cycle completion pulse. The pulse comes with two flags: one copies the interrupt request from the control word, the other marks an error. A descriptor is rejected with the error flag, and moves no data, in three cases: its operation code is one the unit does not support, its XOR source count is out of range, or it asks for XOR without enabling the parity destination.

Top module: `xde_exec_unit`

## Requirements
- R1: After reset, desc_ready is 1, while out_valid, src_ready and done_pulse are 0, and src_ready stays 0 while no descriptor is running.
- R2: The control word is decoded as follows: bits [31:28] are the operation code, bit 27 requests an interrupt, bits [25:22] give the active source count, and bit 17 enables the parity destination. Code 0 is a no-op: it produces no output, and done_pulse is 1 in the cycle after acceptance, with done_irq equal to bit 27 and done_err 0.
- R3: Any operation code other than 0, 1 and 6 completes in the cycle after acceptance with done_err 1 and no output.
- R4: An XOR descriptor (code 6) with source count 0, a source count above 8, or bit 17 clear completes in the cycle after acceptance with done_err 1 and no output.
- R5: A copy (code 1) outputs the words of source index 0 unchanged. It ignores the count field and bits 16 and 17, and it never accepts a word tagged with any other index.
- R6: In XOR mode with count n, output word k is the XOR of word k from sources 0 to n-1, whatever their arrival order. It appears only after all n words have been taken. A second word from an index already taken for word k, or a word with index n or higher, is not accepted.
- R7: A descriptor of size S emits ceil(S/4) words, with out_last set only on the final word. The final word's out_keep has its low S mod 4 bits set, or all four bits when S mod 4 is 0. Data bytes whose keep bit is clear are zero, and every non-final word has all keep bits set.
- R8: While out_valid is 1 and out_ready is 0, out_data, out_keep and out_last hold steady. While an output word is pending, no source word is accepted.
- R9: done_pulse is 1 for the one cycle after the final output handshake, with done_err 0 and done_irq equal to bit 27. A copy or valid XOR descriptor with size 0 completes in the cycle after acceptance with no output.
- R10: desc_ready is 0 from the acceptance of a data-moving descriptor until its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Unit idle, descriptor accepted |
| desc_ctrl | input | 32 | Control word |
| desc_size | input | SIZE_W | Bytes to process |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | Source word accepted |
| src_idx | input | clog2(MAX_SRC) | Source index of the word |
| src_data | input | DATA_W | Source word |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Sink takes result word |
| out_data | output | DATA_W | Result word, masked bytes zero |
| out_keep | output | DATA_W/8 | Valid byte mask |
| out_last | output | 1 | Final word of the descriptor |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_irq | output | 1 | Interrupt requested by the finished descriptor |
| done_err | output | 1 | Finished descriptor was rejected |

## Verification
The hardest state to reach is a partial XOR word under output backpressure. In that state an earlier result is still waiting for the sink, some sources of the next word are already folded in, and the sender retries an index it has already delivered. A directed test holds out_ready low after the first word completes. It then offers a new source word and checks that the word is refused and that the output stays frozen. Next, it releases the sink, feeds one source, and offers the same index again and an out-of-range index, each of which must be refused. The table-driven part rotates the source arrival order per word, so each position sees a different source complete it.

// File: rtl/xde_pkg.sv
// Shared constants and types for the XOR/copy execution unit.
// Assumes a 32-bit control word with the field positions listed below.
package xde_pkg;
    localparam int CTRL_W  = 32;
    localparam int MODE_LSB = 28;
    localparam int MODE_W  = 4;
    localparam int IRQ_BIT = 27;
    localparam int CNT_LSB = 22;
    localparam int CNT_W   = 4;
    localparam int PEN_BIT = 17;

    localparam logic [MODE_W-1:0] OPC_NOP  = 4'd0;
    localparam logic [MODE_W-1:0] OPC_COPY = 4'd1;
    localparam logic [MODE_W-1:0] OPC_XOR  = 4'd6;

    typedef struct packed {
        logic             finish_now;
        logic             err;
        logic             irq;
        logic [CNT_W-1:0] nsrc;
    } dec_t;

    typedef enum logic {ST_IDLE, ST_RUN} st_e;
endpackage

// File: rtl/xde_decode.sv
// Control-word decoder: classifies the descriptor and gives the number of
// sources to gather. Pure combinational; assumes MAX_SRC fits in CNT_W bits.
module xde_decode
    import xde_pkg::*;
#(
    parameter int MAX_SRC = 8
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              size_zero,
    output dec_t              dec
);
    logic [MODE_W-1:0] mode;
    logic [CNT_W-1:0]  cnt;
    logic              unused_ctrl_bits;

    assign mode = ctrl[MODE_LSB +: MODE_W];
    assign cnt  = ctrl[CNT_LSB +: CNT_W];
    assign unused_ctrl_bits = ^{ctrl[IRQ_BIT-1:CNT_LSB+CNT_W],
                                ctrl[CNT_LSB-1:PEN_BIT+1], ctrl[PEN_BIT-1:0]};

    // Classify operation and validate its parameters.
    always_comb begin
        dec     = '0;
        dec.irq = ctrl[IRQ_BIT];
        case (mode)
            OPC_NOP:  dec.finish_now = 1'b1;
            OPC_COPY: begin
                dec.nsrc       = CNT_W'(1);
                dec.finish_now = size_zero;
            end
            OPC_XOR: begin
                if (cnt == '0 || int'(cnt) > MAX_SRC || !ctrl[PEN_BIT]) begin
                    dec.err        = 1'b1;
                    dec.finish_now = 1'b1;
                end else begin
                    dec.nsrc       = cnt;
                    dec.finish_now = size_zero;
                end
            end
            default: begin
                dec.err        = 1'b1;
                dec.finish_now = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xde_accum.sv
// Per-word gatherer: takes one word from each active source in any order,
// XORs them together and flags the word complete on the last one.
// Assumes the owner raises hold in the cycle after word_done.
module xde_accum #(
    parameter int DATA_W  = 32,
    parameter int MAX_SRC = 8,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(MAX_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              hold,
    input  logic [CNT_W-1:0]  nsrc,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              word_done,
    output logic [DATA_W-1:0] word_data
);
    logic [MAX_SRC-1:0] need;
    logic [MAX_SRC-1:0] have;
    logic [MAX_SRC-1:0] have_nx;
    logic [MAX_SRC-1:0] hit;
    logic [DATA_W-1:0]  acc;
    logic               take;

    // One mask bit per source lane that the descriptor activates.
    for (genvar i = 0; i < MAX_SRC; i++) begin : g_need
        assign need[i] = (i < int'(nsrc));
    end

    assign in_ready  = !hold && (int'(in_idx) < int'(nsrc)) && !have[in_idx];
    assign take      = in_valid && in_ready;
    assign word_data = acc ^ in_data;
    assign word_done = take && (have_nx == need);

    // Mark the lane delivered by the current handshake.
    always_comb begin
        hit         = '0;
        hit[in_idx] = take;
        have_nx     = have | hit;
    end

    // Fold accepted words; restart the lane mask once a word completes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || word_done) begin
            have <= '0;
            acc  <= '0;
        end else if (take) begin
            have <= have_nx;
            acc  <= word_data;
        end
    end

    assert_gap_after_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !in_ready);
endmodule

// File: rtl/xde_count.sv
// Word tracker: counts result words left for the descriptor and builds the
// byte-keep mask of the final word. Assumes DATA_W is at least 16.
module xde_count #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16,
    localparam int BPW    = DATA_W / 8,
    localparam int OFF_W  = $clog2(BPW),
    localparam int WCNT_W = SIZE_W - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size,
    input  logic              step,
    output logic              busy,
    output logic              is_last,
    output logic [BPW-1:0]    keep
);
    logic [WCNT_W-1:0] left;
    logic [OFF_W-1:0]  tail;
    logic              partial;

    // Load the rounded-up word count, then count emitted words down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            tail <= '0;
        end else if (load) begin
            left <= WCNT_W'(size >> OFF_W) + WCNT_W'(|size[OFF_W-1:0]);
            tail <= size[OFF_W-1:0];
        end else if (step) begin
            left <= left - WCNT_W'(1);
        end
    end

    assign busy    = (left != '0);
    assign is_last = (left == WCNT_W'(1));
    assign partial = is_last && (tail != '0);

    // Keep the low tail bytes of a partial final word, all bytes otherwise.
    for (genvar b = 0; b < BPW; b++) begin : g_keep
        assign keep[b] = !partial || (b < int'(tail));
    end

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> busy);
endmodule

// File: rtl/xde_exec_unit.sv
// Top of the descriptor execution unit: accepts a descriptor, gathers and
// combines source words, emits masked result words and signals completion.
// Assumes one descriptor at a time; sources follow the word-order contract.
module xde_exec_unit
    import xde_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MAX_SRC = 8,
    parameter int SIZE_W  = 16,
    localparam int KEEP_W = DATA_W / 8,
    localparam int IDX_W  = $clog2(MAX_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [CTRL_W-1:0] desc_ctrl,
    input  logic [SIZE_W-1:0] desc_size,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] src_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [KEEP_W-1:0] out_keep,
    output logic              out_last,
    output logic              done_pulse,
    output logic              done_irq,
    output logic              done_err
);
    st_e               state;
    dec_t              dec;
    logic [CNT_W-1:0]  nsrc_q;
    logic              irq_q;
    logic              desc_fire;
    logic              out_fire;
    logic              hold;
    logic              word_done;
    logic [DATA_W-1:0] word_data;
    logic [DATA_W-1:0] word_masked;
    logic              words_busy;
    logic              word_last;
    logic [KEEP_W-1:0] word_keep;

    assign desc_ready = (state == ST_IDLE);
    assign desc_fire  = desc_valid && desc_ready;
    assign out_fire   = out_valid && out_ready;
    assign hold       = (state != ST_RUN) || out_valid || !words_busy;

    xde_decode #(.MAX_SRC(MAX_SRC)) u_dec (
        .ctrl(desc_ctrl), .size_zero(desc_size == '0), .dec(dec)
    );

    xde_accum #(.DATA_W(DATA_W), .MAX_SRC(MAX_SRC), .CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(desc_fire), .hold(hold),
        .nsrc(nsrc_q), .in_valid(src_valid), .in_idx(src_idx),
        .in_data(src_data), .in_ready(src_ready), .word_done(word_done),
        .word_data(word_data)
    );

    xde_count #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(desc_fire), .size(desc_size),
        .step(word_done), .busy(words_busy), .is_last(word_last),
        .keep(word_keep)
    );

    // Zero every byte that falls outside the keep mask.
    for (genvar b = 0; b < KEEP_W; b++) begin : g_mask
        assign word_masked[8*b +: 8] = word_data[8*b +: 8] & {8{word_keep[b]}};
    end

    // Sequence the descriptor: start, emit words, report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            nsrc_q     <= '0;
            irq_q      <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_keep   <= '0;
            out_last   <= 1'b0;
            done_pulse <= 1'b0;
            done_irq   <= 1'b0;
            done_err   <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (desc_fire) begin
                if (dec.finish_now) begin
                    done_pulse <= 1'b1;
                    done_err   <= dec.err;
                    done_irq   <= dec.irq;
                end else begin
                    state  <= ST_RUN;
                    nsrc_q <= dec.nsrc;
                    irq_q  <= dec.irq;
                end
            end
            if (word_done) begin
                out_valid <= 1'b1;
                out_data  <= word_masked;
                out_keep  <= word_keep;
                out_last  <= word_last;
            end else if (out_fire) begin
                out_valid <= 1'b0;
                if (out_last) begin
                    state      <= ST_IDLE;
                    done_pulse <= 1'b1;
                    done_err   <= 1'b0;
                    done_irq   <= irq_q;
                end
            end
        end
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
        $stable(out_keep) && $stable(out_last));
    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> done_pulse && !done_err);
    assert_reject_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_fire && dec.err |=> done_pulse && done_err && !out_valid);
    assert_busy_no_desc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !desc_ready);
    assert_full_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> (&out_keep));
endmodule

// File: tb/xde_exec_unit_tb.sv
module xde_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] desc_ctrl = '0;
    logic [15:0] desc_size = '0;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [2:0]  src_idx = '0;
    logic [31:0] src_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_keep;
    logic        out_last;
    logic        done_pulse, done_irq, done_err;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xde_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_ctrl(desc_ctrl), .desc_size(desc_size), .src_valid(src_valid),
        .src_ready(src_ready), .src_idx(src_idx), .src_data(src_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last), .done_pulse(done_pulse),
        .done_irq(done_irq), .done_err(done_err)
    );

    // mode, irq, p_en, q_en, count, size, expected error
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {4'd0,  1'b1, 1'b0, 1'b0, 4'd0, 16'd0,  1'b0},
        {4'd5,  1'b0, 1'b1, 1'b0, 4'd1, 16'd16, 1'b1},
        {4'd6,  1'b0, 1'b1, 1'b0, 4'd0, 16'd8,  1'b1},
        {4'd6,  1'b1, 1'b1, 1'b0, 4'd9, 16'd8,  1'b1},
        {4'd6,  1'b0, 1'b0, 1'b0, 4'd3, 16'd8,  1'b1},
        {4'd1,  1'b0, 1'b0, 1'b0, 4'd0, 16'd8,  1'b0},
        {4'd1,  1'b1, 1'b0, 1'b0, 4'd5, 16'd7,  1'b0},
        {4'd6,  1'b0, 1'b1, 1'b0, 4'd1, 16'd4,  1'b0},
        {4'd6,  1'b1, 1'b1, 1'b1, 4'd8, 16'd13, 1'b0},
        {4'd6,  1'b0, 1'b1, 1'b0, 4'd3, 16'd10, 1'b0},
        {4'd1,  1'b1, 1'b0, 1'b0, 4'd0, 16'd0,  1'b0},
        {4'd15, 1'b0, 1'b1, 1'b0, 4'd2, 16'd8,  1'b1},
        {4'd6,  1'b0, 1'b1, 1'b0, 4'd2, 16'd1,  1'b0},
        {4'd8,  1'b0, 1'b1, 1'b1, 4'd2, 16'd8,  1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wd(input int s, input int k);
        logic [31:0] a;
        a = 32'(s + 1) * 32'h1F2E3D4C;
        return a ^ (32'(k) * 32'h00012345) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [3:0] exp_keep(input bit last, input int size);
        if (last && (size % 4) != 0) return 4'((1 << (size % 4)) - 1);
        return 4'hF;
    endfunction

    function automatic logic [31:0] apply_keep(input logic [31:0] d, input logic [3:0] kp);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = d[8*b +: 8] & {8{kp[b]}};
        return r;
    endfunction

    task automatic send_desc(input logic [31:0] ctrl, input int size);
        @(negedge clk);
        desc_valid = 1'b1;
        desc_ctrl  = ctrl;
        desc_size  = 16'(size);
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    // Offer one source word and wait until it is taken.
    task automatic push(input int s, input logic [31:0] d);
        int spin = 0;
        src_valid = 1'b1;
        src_idx   = 3'(s);
        src_data  = d;
        #1;
        while (!src_ready && spin < 1000) begin
            @(negedge clk);
            #1;
            spin++;
        end
        @(posedge clk);
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic run_desc(input logic [27:0] v, input int rot);
        logic [31:0] ctrl;
        logic [31:0] exp;
        logic [3:0]  kp;
        int n, nw, size;
        bit is_data, err;
        string tag;
        ctrl = '0;
        ctrl[31:28] = v[27:24];
        ctrl[27]    = v[23];
        ctrl[17]    = v[22];
        ctrl[16]    = v[21];
        ctrl[25:22] = v[20:17];
        size = int'(v[16:1]);
        err  = v[0];
        is_data = !err && (v[27:24] == 4'd1 || v[27:24] == 4'd6);
        n  = (v[27:24] == 4'd1) ? 1 : int'(v[20:17]);
        nw = is_data ? (size + 3) / 4 : 0;
        if (v[27:24] == 4'd0) tag = "R2";
        else if (err && v[27:24] == 4'd6) tag = "R4";
        else if (err) tag = "R3";
        else if (v[27:24] == 4'd1) tag = "R5";
        else tag = "R6";
        if (nw == 0 && is_data) tag = "R9";
        send_desc(ctrl, size);
        if (nw == 0) begin
            chk(done_pulse == 1'b1, tag, 32'(done_pulse), 1);
            chk(done_err == err, tag, 32'(done_err), 32'(err));
            chk(done_irq == v[23], tag, 32'(done_irq), 32'(v[23]));
            chk(out_valid == 1'b0, tag, 32'(out_valid), 0);
            return;
        end
        chk(desc_ready == 1'b0, "R10", 32'(desc_ready), 0);
        for (int k = 0; k < nw; k++) begin
            exp = '0;
            for (int j = 0; j < n; j++) begin
                int s = (j + k * rot) % n;
                exp ^= wd(s, k);
                push(s, wd(s, k));
            end
            kp  = exp_keep(k == nw - 1, size);
            exp = apply_keep(exp, kp);
            chk(out_valid == 1'b1, tag, 32'(out_valid), 1);
            chk(out_data == exp, tag, out_data, exp);
            chk(out_keep == kp, "R7", 32'(out_keep), 32'(kp));
            chk(out_last == (k == nw - 1), "R7", 32'(out_last), 32'(k == nw - 1));
        end
        @(negedge clk);
        chk(done_pulse == 1'b1, "R9", 32'(done_pulse), 1);
        chk(done_err == 1'b0, "R9", 32'(done_err), 0);
        chk(done_irq == v[23], "R9", 32'(done_irq), 32'(v[23]));
        chk(desc_ready == 1'b1, "R10", 32'(desc_ready), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held;
        logic [31:0] ctrl;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(desc_ready == 1'b1, "R1", 32'(desc_ready), 1);
        chk(out_valid == 1'b0, "R1", 32'(out_valid), 0);
        chk(done_pulse == 1'b0, "R1", 32'(done_pulse), 0);
        rst_n = 1'b1;
        src_valid = 1'b1;
        src_idx = 3'd0;
        #1;
        chk(src_ready == 1'b0, "R1", 32'(src_ready), 0);
        src_valid = 1'b0;

        for (int i = 0; i < NV; i++) run_desc(VEC[i], i % 3);

        // Backpressure, repeated index and out-of-range index (R6, R8).
        ctrl = '0;
        ctrl[31:28] = 4'd6;
        ctrl[25:22] = 4'd2;
        ctrl[17] = 1'b1;
        send_desc(ctrl, 8);
        out_ready = 1'b0;
        push(1, wd(1, 0));
        push(0, wd(0, 0));
        chk(out_data == (wd(0, 0) ^ wd(1, 0)), "R6", out_data, wd(0, 0) ^ wd(1, 0));
        held = out_data;
        src_valid = 1'b1;
        src_idx = 3'd0;
        src_data = wd(0, 1);
        #1;
        chk(src_ready == 1'b0, "R8", 32'(src_ready), 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == held, "R8", out_data, held);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        push(0, wd(0, 1));
        src_valid = 1'b1;
        src_idx = 3'd0;
        #1;
        chk(src_ready == 1'b0, "R6", 32'(src_ready), 0);
        src_idx = 3'd2;
        #1;
        chk(src_ready == 1'b0, "R6", 32'(src_ready), 0);
        chk(desc_ready == 1'b0, "R10", 32'(desc_ready), 0);
        push(1, wd(1, 1));
        chk(out_data == (wd(0, 1) ^ wd(1, 1)) && out_last, "R6", out_data, wd(0, 1) ^ wd(1, 1));
        @(negedge clk);
        chk(done_pulse == 1'b1, "R9", 32'(done_pulse), 1);

        // Copy refuses any index other than 0 (R5).
        ctrl = '0;
        ctrl[31:28] = 4'd1;
        send_desc(ctrl, 4);
        src_valid = 1'b1;
        src_idx = 3'd1;
        #1;
        chk(src_ready == 1'b0, "R5", 32'(src_ready), 0);
        push(0, 32'hCAFE1234);
        chk(out_data == 32'hCAFE1234 && out_last, "R5", out_data, 32'hCAFE1234);
        @(negedge clk);
        chk(done_pulse == 1'b1, "R9", 32'(done_pulse), 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule